// File: doc/BRIEF.md
# DRAM Hidden-Refresh Scheduler

This block keeps a four-bank dynamic RAM array refreshed from a slow, free-running refresh clock. While that clock is high, any cycle in which the host leaves chip select inactive but still pulses the RAS input strobe becomes a refresh: all four RAS outputs drop together and a 9-bit row counter is presented as the refresh row. Such a hidden refresh costs the host no access time.

A credit flag records whether a hidden refresh finished during the current refresh clock period. When the refresh clock falls without that credit, the block pulls its active-low request line down. The host then either selects the automatic mode, in which the block runs a timed RAS pulse and precharge on its own, or selects the external mode, in which the host's own RAS input strobe drives the refresh. The request is withdrawn when the automatic refresh finishes, or on the first cycle of the external mode. Outside refresh, the block decodes a two-bit bank address onto one RAS output and passes the CAS input strobe through. All outputs are registered, so each one follows its inputs by one clock.

Top module: `hidref_sched`

## Requirements
- R1: During and right after a synchronous reset all RAS outputs are high, CAS is high, the request line is high (inactive), the violation flag is low and the row counter is 0.
- R2: With no refresh in progress, chip select low and the RAS input strobe low select one bank: one clock later only bit `bank_i` of `ras_n_o` is low. CAS output follows the CAS input strobe one clock later. Mode encoding: 0 normal, 1 automatic, 2 external, 3 behaves as normal.
- R3: In normal mode, chip select high, the RAS input strobe low and the refresh clock high start a hidden refresh. One clock later all four RAS outputs are low and CAS is held high. With the refresh clock low, the same inputs leave the RAS outputs high.
- R4: A hidden refresh holds all RAS outputs low until the RAS input strobe is sampled high, even across a fall of the refresh clock. In the clock after that, the RAS outputs go high and the row counter is one higher. A fall of the refresh clock that happens during the refresh, or after it within the same period, raises no request.
- R5: If chip select is sampled low during a hidden refresh, `cs_viol_o` is high in the next clock and the refresh continues.
- R6: If the refresh clock is sampled falling and no hidden refresh has completed since its last rise, `req_n_o` is low one clock later.
- R7: In automatic mode with a request pending, the RAS outputs are low for RAS_CYC clocks and then high for PRE_CYC clocks. After that, the request line goes high and the row counter increments.
- R8: Entering external mode raises the request line one clock later. While in that mode, the RAS outputs follow the RAS input strobe one clock later, and the row counter increments each time the strobe rises.
- R9: The row counter is 9 bits wide and wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rfclk_i | input | 1 | Refresh clock, already synchronous to clk |
| mode_i | input | 2 | 0 normal, 1 automatic refresh, 2 external refresh, 3 normal |
| cs_n_i | input | 1 | Chip select, active low |
| rasin_n_i | input | 1 | RAS input strobe, active low |
| casin_n_i | input | 1 | CAS input strobe, active low |
| bank_i | input | 2 | Bank address for accesses |
| ras_n_o | output | 4 | Per-bank RAS strobes, active low |
| cas_n_o | output | 1 | Shared CAS strobe, active low |
| req_n_o | output | 1 | Refresh request, active low |
| row_o | output | 9 | Refresh row counter |
| cs_viol_o | output | 1 | Chip select went low during a hidden refresh |

## Verification
If the credit flag is wrong, the first missed refresh clock period shows it. The request line either drops after a period that did have a hidden refresh, or stays high after one that did not, and this is visible one clock after the fall. If the sequencer state or its counter is wrong, the RAS pulse or precharge comes out the wrong length in automatic mode, or the RAS outputs fail to stay low across a refresh clock fall, within a few clocks. A wrong row counter appears at `row_o` as soon as the next refresh completes. The sweep through a full row cycle exposes any fault at the wrap.

// File: rtl/hrc_pkg.sv
// Shared types for the hidden-refresh scheduler.
// Assumes: mode code 3 is treated the same as normal operation.
package hrc_pkg;
    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_AUTO = 2'd1,
        MODE_EXT  = 2'd2,
        MODE_ALT  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HIDDEN   = 3'd1,
        ST_AUTO_RAS = 3'd2,
        ST_AUTO_PRE = 3'd3,
        ST_EXT      = 3'd4
    } st_e;
endpackage

// File: rtl/hrc_edge.sv
// Edge detector for the refresh clock level.
// Assumes: lvl_i is already synchronous to clk.
module hrc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic lvl_q;

    // Keep the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    // Compare the current level with the previous sample.
    always_comb begin
        rise_o = lvl_i & ~lvl_q;
        fall_o = ~lvl_i & lvl_q;
    end
endmodule

// File: rtl/hrc_seq.sv
// Refresh sequencer: hidden refresh detection, the period credit flag,
// the request line, the automatic refresh timer and the external mode.
// It gives the RAS driver the next-cycle ownership and level, and gives
// the row counter a one-cycle increment strobe.
// Assumes: RAS_CYC and PRE_CYC are at least 1.
module hrc_seq #(
    parameter int RAS_CYC = 4,
    parameter int PRE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       cs_n_i,
    input  logic       rasin_n_i,
    input  logic       rfclk_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       busy_nx_o,
    output logic       low_nx_o,
    output logic       inc_o,
    output logic       req_pend_o,
    output logic       viol_o
);
    import hrc_pkg::*;

    localparam int CMAX  = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
    localparam int CNT_W = $clog2(CMAX + 1);

    st_e              st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rasin_q, done_q, req_q, viol_q;
    mode_e            mode;
    logic             ext_go, auto_go, hid_go, hid_end, auto_end, ext_rise;

    assign mode = mode_e'(mode_i);

    // Decode the start and end conditions seen in this cycle.
    always_comb begin
        ext_go   = (st_q == ST_IDLE) && (mode == MODE_EXT);
        auto_go  = (st_q == ST_IDLE) && (mode == MODE_AUTO) && req_q;
        hid_go   = (st_q == ST_IDLE) && (mode != MODE_EXT) && (mode != MODE_AUTO)
                   && cs_n_i && !rasin_n_i && rfclk_i;
        hid_end  = (st_q == ST_HIDDEN) && rasin_n_i;
        auto_end = (st_q == ST_AUTO_PRE) && (cnt_q == CNT_W'(PRE_CYC - 1));
        ext_rise = (st_q == ST_EXT) && rasin_n_i && !rasin_q;
    end

    // Next state and the timer count.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (ext_go)       st_d = ST_EXT;
                else if (auto_go) st_d = ST_AUTO_RAS;
                else if (hid_go)  st_d = ST_HIDDEN;
            end
            ST_HIDDEN: if (hid_end) st_d = ST_IDLE;
            ST_AUTO_RAS: begin
                if (cnt_q == CNT_W'(RAS_CYC - 1)) begin
                    st_d  = ST_AUTO_PRE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_AUTO_PRE: begin
                if (auto_end) st_d = ST_IDLE;
                else          cnt_d = cnt_q + 1'b1;
            end
            ST_EXT: if (mode != MODE_EXT) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Tell the RAS driver who owns the strobes next cycle, and at what level.
    always_comb begin
        busy_nx_o = (st_d != ST_IDLE);
        unique case (st_d)
            ST_HIDDEN, ST_AUTO_RAS: low_nx_o = 1'b1;
            ST_EXT:                 low_nx_o = !rasin_n_i;
            default:                low_nx_o = 1'b0;
        endcase
        inc_o = hid_end || auto_end || ext_rise;
    end

    // State, timer and the previous strobe sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            rasin_q <= 1'b1;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            rasin_q <= rasin_n_i;
        end
    end

    // Period credit: set by a finished hidden refresh, cleared on a rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       done_q <= 1'b0;
        else if (hid_end) done_q <= 1'b1;
        else if (rise_i)  done_q <= 1'b0;
    end

    // Request: raised on an uncredited fall, withdrawn when serviced.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          req_q <= 1'b0;
        else if (ext_go || auto_end)                         req_q <= 1'b0;
        else if (fall_i && !done_q && (st_q != ST_HIDDEN))   req_q <= 1'b1;
    end

    // Flag chip select going active during a hidden refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= (st_q == ST_HIDDEN) && !cs_n_i;
    end

    assign req_pend_o = req_q;
    assign viol_o     = viol_q;
endmodule

// File: rtl/hrc_ras_drive.sv
// Registered RAS and CAS drivers. When a refresh owns the strobes, all
// banks are driven together; otherwise an access drives only its bank.
// Assumes: BANKS is a power of two.
module hrc_ras_drive #(
    parameter int BANKS = 4,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_nx_i,
    input  logic              low_nx_i,
    input  logic              cs_n_i,
    input  logic              rasin_n_i,
    input  logic              casin_n_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [BANKS-1:0]  ras_n_o,
    output logic              cas_n_o
);
    logic             acc;
    logic [BANKS-1:0] ras_d;

    assign acc = !cs_n_i && !rasin_n_i;

    // One driver per bank: refresh level, or bank decode for an access.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_comb begin
            if (busy_nx_i) ras_d[b] = !low_nx_i;
            else           ras_d[b] = !(acc && (bank_i == BANK_W'(b)));
        end
    end

    // Register the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n_o <= '1;
            cas_n_o <= 1'b1;
        end else begin
            ras_n_o <= ras_d;
            cas_n_o <= busy_nx_i ? 1'b1 : casin_n_i;
        end
    end
endmodule

// File: rtl/hrc_row_ctr.sv
// Refresh row counter; it wraps at its full width.
// Assumes: inc_i is high for one cycle per completed refresh.
module hrc_row_ctr #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [ROW_W-1:0] row_o
);
    // Count completed refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n)     row_o <= '0;
        else if (inc_i) row_o <= row_o + ROW_W'(1);
    end
endmodule

// File: rtl/hidref_sched.sv
// Top of the hidden-refresh scheduler: edge detection, sequencer, RAS/CAS
// driver and row counter.
// Assumes: every input is synchronous to clk; reset is synchronous, active low.
module hidref_sched #(
    parameter int ROW_W   = 9,
    parameter int BANKS   = 4,
    parameter int RAS_CYC = 4,
    parameter int PRE_CYC = 3,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rfclk_i,
    input  logic [1:0]        mode_i,
    input  logic              cs_n_i,
    input  logic              rasin_n_i,
    input  logic              casin_n_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [BANKS-1:0]  ras_n_o,
    output logic              cas_n_o,
    output logic              req_n_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              cs_viol_o
);
    logic rise, fall, busy_nx, low_nx, inc, req_pend;

    hrc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(rfclk_i), .rise_o(rise), .fall_o(fall)
    );

    hrc_seq #(.RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cs_n_i(cs_n_i),
        .rasin_n_i(rasin_n_i), .rfclk_i(rfclk_i), .rise_i(rise), .fall_i(fall),
        .busy_nx_o(busy_nx), .low_nx_o(low_nx), .inc_o(inc),
        .req_pend_o(req_pend), .viol_o(cs_viol_o)
    );

    hrc_ras_drive #(.BANKS(BANKS)) u_drive (
        .clk(clk), .rst_n(rst_n), .busy_nx_i(busy_nx), .low_nx_i(low_nx),
        .cs_n_i(cs_n_i), .rasin_n_i(rasin_n_i), .casin_n_i(casin_n_i),
        .bank_i(bank_i), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o)
    );

    hrc_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .inc_i(inc), .row_o(row_o)
    );

    assign req_n_o = !req_pend;
endmodule

// File: rtl/hidref_sched_chk.sv
// Port-level property checker for the hidden-refresh scheduler.
// Assumes: attached to every instance through the bind below.
module hidref_sched_chk #(
    parameter int ROW_W = 9,
    parameter int BANKS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rfclk_i,
    input logic             cs_n_i,
    input logic [BANKS-1:0] ras_n_o,
    input logic             cas_n_o,
    input logic             req_n_o,
    input logic [ROW_W-1:0] row_o,
    input logic             cs_viol_o
);
    AST_RAS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~ras_n_o) <= 1) || (ras_n_o == '0));  // R2
    AST_CAS_IDLE_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n_o == '0) |-> cas_n_o);  // R3
    AST_REQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n_o) |-> (!$past(rfclk_i) && $past(rfclk_i, 2)));  // R6
    AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_viol_o |-> (!$past(cs_n_i) && ($past(ras_n_o) == '0)));  // R5
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (row_o != $past(row_o)) |-> (row_o == ROW_W'($past(row_o) + 1'b1)));  // R9
endmodule

bind hidref_sched hidref_sched_chk #(.ROW_W(ROW_W), .BANKS(BANKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rfclk_i(rfclk_i), .cs_n_i(cs_n_i),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .req_n_o(req_n_o),
    .row_o(row_o), .cs_viol_o(cs_viol_o)
);

// File: tb/hidref_sched_bench.sv
module hidref_sched_bench;
    localparam int RC = 4;
    localparam int PC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rfclk = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       cs_n = 1'b1, rasin_n = 1'b1, casin_n = 1'b1;
    logic [1:0] bank = 2'd0;
    logic [3:0] ras_n;
    logic       cas_n, req_n, viol;
    logic [8:0] row;
    int         nchk = 0, nfail = 0;
    int         exp_row = 0;

    always #5 clk = ~clk;

    hidref_sched #(.RAS_CYC(RC), .PRE_CYC(PC)) u_hidref_sched (
        .clk(clk), .rst_n(rst_n), .rfclk_i(rfclk), .mode_i(mode),
        .cs_n_i(cs_n), .rasin_n_i(rasin_n), .casin_n_i(casin_n), .bank_i(bank),
        .ras_n_o(ras_n), .cas_n_o(cas_n), .req_n_o(req_n), .row_o(row),
        .cs_viol_o(viol)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) tick();
        chk("R1 ras", ras_n, 4'hF); chk("R1 cas", cas_n, 1); chk("R1 req", req_n, 1);
        chk("R1 row", row, 0); chk("R1 viol", viol, 0);
        rst_n = 1'b1; tick();
        chk("R1 ras after", ras_n, 4'hF); chk("R1 row after", row, 0);

        // R2 bank decode and CAS pass-through, all banks
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 2; c++) begin
                bank = 2'(b); cs_n = 0; rasin_n = 0; casin_n = c[0];
                tick();
                chk("R2 ras", ras_n, (~(4'b1 << b)) & 4'hF);
                chk("R2 cas", cas_n, c);
                cs_n = 1; rasin_n = 1; casin_n = 1; tick();
                chk("R2 idle", ras_n, 4'hF);
            end
        end

        // R3/R4 hidden refresh spanning a refresh clock fall
        rfclk = 1; tick();
        cs_n = 1; rasin_n = 0; casin_n = 0; tick();
        chk("R3 ras all low", ras_n, 0); chk("R3 cas held", cas_n, 1);
        rfclk = 0; tick(); tick();
        chk("R4 held across fall", ras_n, 0);
        rasin_n = 1; casin_n = 1; tick(); exp_row++;
        chk("R4 ras end", ras_n, 4'hF); chk("R4 row", row, exp_row);
        tick(); chk("R4 no request", req_n, 1);

        // R6 missed period
        rfclk = 1; tick(); rfclk = 0; tick();
        chk("R6 request", req_n, 0);

        // R7 automatic refresh timing
        mode = 2'd1;
        for (int i = 1; i <= RC + PC + 1; i++) begin
            tick();
            chk("R7 ras", ras_n, (i <= RC) ? 0 : 4'hF);
            chk("R7 req", req_n, (i <= RC + PC) ? 0 : 1);
            if (i == RC + PC + 1) exp_row++;
            chk("R7 row", row, exp_row);
        end
        mode = 2'd0; tick();

        // R8 external refresh
        rfclk = 1; tick(); rfclk = 0; tick();
        chk("R6 request again", req_n, 0);
        mode = 2'd2; tick();
        chk("R8 req cleared on entry", req_n, 1); chk("R8 ras", ras_n, 4'hF);
        rasin_n = 0; tick(); chk("R8 ras low", ras_n, 0);
        rasin_n = 1; tick(); exp_row++;
        chk("R8 ras high", ras_n, 4'hF); chk("R8 row", row, exp_row);
        mode = 2'd0; tick();

        // R5 chip select violation
        rfclk = 1; tick();
        cs_n = 1; rasin_n = 0; tick();
        cs_n = 0; tick();
        chk("R5 viol", viol, 1); chk("R5 continues", ras_n, 0);
        cs_n = 1; tick(); chk("R5 viol clear", viol, 0);
        rasin_n = 1; tick(); exp_row++;
        chk("R5 row", row, exp_row);

        // R4 credit and R3 no start while refresh clock low
        rfclk = 0; tick(); tick();
        chk("R4 credit keeps req high", req_n, 1);
        rasin_n = 0; tick();
        chk("R3 no start low rfclk", ras_n, 4'hF); chk("R3 row unchanged", row, exp_row);
        rasin_n = 1; tick();

        // R9 full row sweep through the wrap
        rfclk = 1; tick();
        for (int k = 0; k < 520; k++) begin
            rasin_n = 0; tick();
            rasin_n = 1; tick();
            exp_row = (exp_row + 1) % 512;
            chk("R9 row", row, exp_row);
        end
        chk("R9 final", row, (4 + 520) % 512);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule